// File: doc/BRIEF.md
# Lockable Translation Lookaside Buffer

This block is a fully associative address translation cache with a parameterised number of entries (32 by default). Each entry holds a tag word (virtual page tag, page-size code, valid and preserved flags) and a data word (physical page and memory attributes). Software fills an entry by writing the two words into staging registers and then strobing a load command. The entry written is the one named by a victim pointer. After each load the pointer steps forward, and when it passes the last entry it wraps back to a lock base. Entries below the lock base are therefore never chosen for replacement.

A lookup port compares a virtual address against every valid entry at once. Each comparison is masked by that entry's own page size. The block returns the translated physical address, the attribute bits, a hit flag and a multiple-hit flag one cycle later. Entries can be removed in two ways: one at a time by tag and size, or all together with a global flush. The global flush spares entries marked preserved. Lookup misses and multiple hits set sticky status bits, and an enable mask turns these bits into a level interrupt.

Register select codes on `wr_sel` / `rd_sel`:

| Code | Register |
|------|----------|
| 0 | tag staging |
| 1 | data staging |
| 2 | lock |
| 3 | load |
| 4 | single flush |
| 5 | global flush |
| 6 | status (write 1 to clear) |
| 7 | interrupt enable |

Top module: `tlb_cam`

## Requirements
- R1: After reset every entry is invalid. The lock register, status, enable, staging registers, `lk_hit`, `lk_multi` and `irq` all read 0.
- R2: Writing code 3 with data bit 0 set copies the tag staging word and the data staging word into the entry at the victim index. The tag staging word has tag in bits 31:12, preserved in bit 3, valid in bit 2 and size in bits 1:0. The data staging word has the physical page in bits 31:12, endianness in bit 9, element size in bits 8:7 and mixed-size select in bit 6.
- R3: The lock register (code 2) holds the lock base in bits 15:10 and the victim index in bits 9:4. Each load advances the victim by one. A load made when the victim is at the last entry sets the victim to the lock base instead.
- R4: The lookup compares virtual address bits 31:24, 31:20, 31:16 or 31:12 for size codes 3 (16 MB), 0 (1 MB), 1 (64 KB) and 2 (4 KB). The returned address is the entry's physical page bits over that same range, with the remaining low bits taken from the virtual address.
- R5: `lk_attr` returns the hit entry's data word bits 9:6 in the order {endianness, element size, mixed select}.
- R6: When more than one entry matches, the lowest-index entry supplies the result and `lk_multi` is 1.
- R7: Writing code 4 with bit 0 set invalidates every entry whose size equals the staged size and whose tag matches the staged tag under that size, including preserved entries. An entry of a different size is untouched.
- R8: Writing code 5 with bit 0 set invalidates all entries except those with the preserved flag set.
- R9: Status bit 1 is set on a lookup miss and status bit 0 on a multiple hit. Writing code 6 clears every status bit written as 1, and a set in the same cycle wins. `irq` is high while any status bit is set whose enable bit (code 7, 5 bits) is also set.
- R10: Lookup results appear on the cycle after `lk_valid` is sampled and hold until the next lookup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register select for combinational reads |
| rd_data | output | 32 | Read data |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_multi | output | 1 | More than one entry matched |
| lk_paddr | output | 32 | Translated physical address |
| lk_attr | output | 4 | Attributes of the hit entry |
| irq | output | 1 | Enabled status pending |

## Verification
The assertions take two things for granted about the inputs. First, software never writes a victim index at or beyond the entry count. Second, a status acknowledge is only checked in cycles without a concurrent lookup, because a new event may legitimately re-set a bit in that cycle. The stimulus respects both: it only writes victim values inside the array, and it issues writes and lookups in separate cycles. Entries are placed so that overlapping pages of different sizes exercise the multiple-hit priority and the size-qualified flush.

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_sel,
  output logic [31:0] rd_data,
  input  logic        lk_valid,
  input  logic [31:0] lk_vaddr,
  output logic        lk_hit,
  output logic        lk_multi,
  output logic [31:0] lk_paddr,
  output logic [3:0]  lk_attr,
  output logic        irq
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [5:0] LAST = 6'(N - 1);

  logic [19:0] tag [N];
  logic [1:0]  psz [N];
  logic [19:0] pa  [N];
  logic [3:0]  atr [N];
  logic [N-1:0] vld, prs;

  logic [31:0] cam_stg, ram_stg;
  logic [5:0]  lock_base, victim;
  logic [4:0]  st, en;

  function automatic logic [19:0] size_mask(input logic [1:0] s);
    case (s)
      2'd0:    size_mask = 20'hFFF00;
      2'd1:    size_mask = 20'hFFFF0;
      2'd2:    size_mask = 20'hFFFFF;
      default: size_mask = 20'hFF000;
    endcase
  endfunction

  wire do_load   = wr_en && wr_sel == 3'd3 && wr_data[0];
  wire do_fone   = wr_en && wr_sel == 3'd4 && wr_data[0];
  wire do_fall   = wr_en && wr_sel == 3'd5 && wr_data[0];
  wire [4:0] ack = (wr_en && wr_sel == 3'd6) ? wr_data[4:0] : 5'd0;

  logic [N-1:0] match, fmatch;
  logic          hit_any, two;
  logic [IW-1:0] hit_idx;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      match[i]  = vld[i] && (((tag[i] ^ lk_vaddr[31:12]) & size_mask(psz[i])) == 20'd0);
      fmatch[i] = vld[i] && psz[i] == cam_stg[1:0] &&
                  (((tag[i] ^ cam_stg[31:12]) & size_mask(psz[i])) == 20'd0);
    end
    hit_any = 1'b0;
    two     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) begin
        if (hit_any) two = 1'b1;
        else hit_idx = IW'(i);
        hit_any = 1'b1;
      end
    end
  end

  wire [31:0] hmask = {size_mask(psz[hit_idx]), 12'h000};
  wire [31:0] xlate = ({pa[hit_idx], 12'h000} & hmask) | (lk_vaddr & ~hmask);
  wire [4:0]  st_set = lk_valid ? {3'd0, ~hit_any, two} : 5'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        tag[i] <= '0;
        psz[i] <= '0;
        pa[i]  <= '0;
        atr[i] <= '0;
      end
      vld <= '0;
      prs <= '0;
    end else if (do_load) begin
      tag[victim[IW-1:0]] <= cam_stg[31:12];
      psz[victim[IW-1:0]] <= cam_stg[1:0];
      vld[victim[IW-1:0]] <= cam_stg[2];
      prs[victim[IW-1:0]] <= cam_stg[3];
      pa[victim[IW-1:0]]  <= ram_stg[31:12];
      atr[victim[IW-1:0]] <= ram_stg[9:6];
    end else if (do_fone) begin
      vld <= vld & ~fmatch;
    end else if (do_fall) begin
      vld <= vld & prs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cam_stg   <= '0;
      ram_stg   <= '0;
      lock_base <= '0;
      victim    <= '0;
      st        <= '0;
      en        <= '0;
    end else begin
      st <= (st & ~ack) | st_set;
      if (wr_en) begin
        case (wr_sel)
          3'd0: cam_stg <= wr_data;
          3'd1: ram_stg <= wr_data;
          3'd2: begin
            lock_base <= wr_data[15:10];
            victim    <= wr_data[9:4];
          end
          3'd3: if (wr_data[0]) victim <= (victim >= LAST) ? lock_base : victim + 6'd1;
          3'd7: en <= wr_data[4:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_hit   <= 1'b0;
      lk_multi <= 1'b0;
      lk_paddr <= '0;
      lk_attr  <= '0;
    end else if (lk_valid) begin
      lk_hit   <= hit_any;
      lk_multi <= two;
      lk_paddr <= hit_any ? xlate : 32'd0;
      lk_attr  <= hit_any ? atr[hit_idx] : 4'd0;
    end
  end

  assign irq = |(st & en);

  always_comb begin
    case (rd_sel)
      3'd0:    rd_data = cam_stg;
      3'd1:    rd_data = ram_stg;
      3'd2:    rd_data = {16'd0, lock_base, victim, 4'd0};
      3'd6:    rd_data = {27'd0, st};
      3'd7:    rd_data = {27'd0, en};
      default: rd_data = 32'd0;
    endcase
  end
endmodule

// File: rtl/tlb_cam_chk.sv
module tlb_cam_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [2:0]   wr_sel,
  input logic [31:0]  wr_data,
  input logic         lk_valid,
  input logic         lk_hit,
  input logic         lk_multi,
  input logic [5:0]   victim,
  input logic [5:0]   lock_base,
  input logic [4:0]   st,
  input logic [N-1:0] vld,
  input logic [N-1:0] prs
);
  AST_VICTIM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd3 && wr_data[0]) |=>
      (victim == $past(victim) + 6'd1 || victim == $past(lock_base))); // R3

  AST_MULTI_HAS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_multi |-> lk_hit); // R6

  AST_MISS_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid ##1 !lk_hit) |-> st[1]); // R9

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd6 && !lk_valid) |=> ((st & $past(wr_data[4:0])) == 5'd0)); // R9

  AST_GFLUSH_KEEPS_PRESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd5 && wr_data[0]) |=> ((vld & ~prs) == '0)); // R8
endmodule

bind tlb_cam tlb_cam_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_multi(lk_multi),
  .victim(victim), .lock_base(lock_base), .st(st), .vld(vld), .prs(prs)
);

// File: tb/tlb_cam_tb.sv
module tlb_cam_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, lk_valid = 1'b0;
  logic [2:0] wr_sel = '0, rd_sel = '0;
  logic [31:0] wr_data = '0, lk_vaddr = '0;
  logic [31:0] rd_data, lk_paddr;
  logic lk_hit, lk_multi, irq;
  logic [3:0] lk_attr;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tlb_cam #(.N(32)) u_dut (.*);

  // {vaddr, hit, multi, paddr, attr}
  localparam logic [69:0] VEC [9] = '{
    {32'h0001_2ABC, 1'b1, 1'b0, 32'h8000_0ABC, 4'hC},
    {32'h0001_3000, 1'b0, 1'b0, 32'h0000_0000, 4'h0},
    {32'h0034_F123, 1'b1, 1'b0, 32'h9000_F123, 4'h1},
    {32'h0035_0000, 1'b0, 1'b0, 32'h0000_0000, 4'h0},
    {32'h050A_BCDE, 1'b1, 1'b0, 32'hA01A_BCDE, 4'h2},
    {32'h70FF_FFFC, 1'b1, 1'b0, 32'hB0FF_FFFC, 4'h0},
    {32'h7100_0000, 1'b0, 1'b0, 32'h0000_0000, 4'h0},
    {32'h0500_3010, 1'b1, 1'b1, 32'hA010_3010, 4'h2},
    {32'h0500_4010, 1'b1, 1'b0, 32'hA010_4010, 4'h2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk);
    rd_sel = s;
    #1 d = rd_data;
  endtask

  task automatic load(input logic [31:0] cam, input logic [31:0] ram);
    wr(3'd0, cam);
    wr(3'd1, ram);
    wr(3'd3, 32'd1);
  endtask

  task automatic look(input logic [31:0] va);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk("R1 hit", {31'd0, lk_hit}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(3'd2, r); chk("R1 lock", r, 32'd0);
    rd(3'd6, r); chk("R1 status", r, 32'd0);
    look(32'h0001_2000);
    chk("R1 no valid entries", {31'd0, lk_hit}, 32'd0);
    wr(3'd6, 32'h1F);

    // R2 loads at victim 0..4
    load(32'h0001_2006, 32'h8000_0300);
    load(32'h0034_0005, 32'h9000_0040);
    load(32'h0500_000C, 32'hA010_0080);
    load(32'h7000_0007, 32'hB000_0000);
    load(32'h0500_3006, 32'hC000_0000);
    rd(3'd2, r); chk("R3 victim after five loads", r, 32'h0000_0050);

    // R4 R5 R6 R10 vector table
    for (int i = 0; i < 9; i++) begin
      look(VEC[i][69:38]);
      chk("R4 hit", {31'd0, lk_hit}, {31'd0, VEC[i][37]});
      chk("R6 multi", {31'd0, lk_multi}, {31'd0, VEC[i][36]});
      if (VEC[i][37]) begin
        chk("R4 paddr", lk_paddr, VEC[i][35:4]);
        chk("R5 attr", {28'd0, lk_attr}, {28'd0, VEC[i][3:0]});
      end
    end
    @(negedge clk);
    chk("R10 result held", lk_paddr, 32'hA010_4010);

    // R9 status and interrupt
    rd(3'd6, r); chk("R9 status miss+multi", r, 32'h3);
    chk("R9 irq masked", {31'd0, irq}, 32'd0);
    wr(3'd7, 32'h2);
    chk("R9 irq enabled", {31'd0, irq}, 32'd1);
    wr(3'd6, 32'h2);
    rd(3'd6, r); chk("R9 ack bit1", r, 32'h1);
    chk("R9 irq after ack", {31'd0, irq}, 32'd0);
    wr(3'd6, 32'h1);
    rd(3'd6, r); chk("R9 ack bit0", r, 32'h0);

    // R7 flush-one with wrong size leaves entry 1
    wr(3'd0, 32'h0034_0002);
    wr(3'd4, 32'd1);
    look(32'h0034_0000);
    chk("R7 size mismatch kept", {31'd0, lk_hit}, 32'd1);
    // R7 flush-one matching entry 0
    wr(3'd0, 32'h0001_2002);
    wr(3'd4, 32'd1);
    look(32'h0001_2ABC);
    chk("R7 flushed entry", {31'd0, lk_hit}, 32'd0);

    // R8 global flush keeps preserved
    wr(3'd5, 32'd1);
    look(32'h0500_3010);
    chk("R8 preserved hit", {31'd0, lk_hit}, 32'd1);
    chk("R8 no second hit", {31'd0, lk_multi}, 32'd0);
    look(32'h7000_0000);
    chk("R8 plain entry gone", {31'd0, lk_hit}, 32'd0);
    // R7 flush-one removes preserved entry
    wr(3'd0, 32'h0500_0000);
    wr(3'd4, 32'd1);
    look(32'h0500_3010);
    chk("R7 preserved flushed", {31'd0, lk_hit}, 32'd0);

    // R3 lock base and wrap
    wr(3'd2, (32'd30 << 10) | (32'd30 << 4));
    rd(3'd2, r); chk("R3 lock write", r, 32'h0000_79E0);
    load(32'h0010_0006, 32'hD000_0000);
    load(32'h0020_0006, 32'hD100_0000);
    rd(3'd2, r); chk("R3 wrap to base", r, 32'h0000_79E0);
    load(32'h0030_0006, 32'hD200_0000);
    rd(3'd2, r); chk("R3 step after wrap", r, 32'h0000_79F0);
    look(32'h0010_0000);
    chk("R2 slot 30 overwritten", {31'd0, lk_hit}, 32'd0);
    look(32'h0030_0444);
    chk("R2 new entry paddr", lk_paddr, 32'hD200_0444);
    look(32'h0020_0010);
    chk("R2 slot 31 kept", lk_paddr, 32'hD100_0010);

    finished = 1'b1;
    summary();
  end
endmodule